// File: doc/BRIEF.md
# Predicated ALU with Status Flags

This block is the arithmetic/logic stage of a 16-bit fixed-point signal-processing datapath. Each operation arrives with a condition code. The block evaluates that code against its own status word. When the condition holds, the block computes the operation and writes the result into one of two destination registers, either the main result register or the feedback register. It also refreshes the zero, negative, overflow, carry and X-sign flags. When the condition fails, the operation does nothing at all.

The arithmetic operations are add, add with carry, add a constant, subtract, and reverse subtract. Both subtract forms have a borrow variant. There are also negate, absolute value, increment and decrement. The logical operations are AND, OR and XOR against Y or a constant, plus pass, invert, and single-bit test, set, clear and toggle. Two mode inputs control the results. One saturates the main result register on overflow. The other holds the overflow flag once it is set. The multiplier overflow flag is supplied from outside and kept in the same status word, so that conditions can test it.

All outputs are registered. An operation sampled on one rising edge is visible on the outputs after that edge.

Top module: `pred_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `ar`, `af`, `astat` and `exec` all become zero.
- R2: Arithmetic opcodes, with C = `cin` and K = `kval`. All results are taken modulo 2^16.
  - 0: X+Y
  - 1: X+Y+C
  - 2: X+C
  - 3: X+K
  - 4: X-Y
  - 5: X-Y+C-1
  - 6: Y-X
  - 7: Y-X+C-1
  - 8: -X
  - 19: absolute value of X
  - 20: Y+1
  - 21: Y-1
- R3: Logical opcodes, with n = `bit_n`:
  - 9, 10, 11: X AND Y, X OR Y, X XOR Y
  - 12, 13, 14: X AND K, X OR K, X XOR K
  - 15, 16, 17: pass X, pass Y, pass K
  - 18: NOT X
  - 22: X AND (1<<n)
  - 23: X OR (1<<n)
  - 24: X AND NOT (1<<n)
  - 25: X XOR (1<<n)
  
  Each of these ops clears AV and AC.
- R4: Condition codes on `cond`:
  - 0 EQ: AZ
  - 1 NE: !AZ
  - 2 GT: !((AN^AV)|AZ)
  - 3 LE: (AN^AV)|AZ
  - 4 LT: AN^AV
  - 5 GE: !(AN^AV)
  - 6 AV
  - 7 !AV
  - 8 AC
  - 9 !AC
  - 10 NEG: AS
  - 11 POS: !AS
  - 12 MV
  - 13 !MV
  - 14 never
  - 15 always
- R5: If `op_valid` is low, the condition is false, or the opcode is 26 to 31, then `ar`, `af` and `astat` bits 0 to 4 keep their values.
- R6: An executed operation writes `af` when `to_fb` is 1 and `ar` when it is 0. It never writes both.
- R7: `astat` layout:
  - bit0 AZ: result is zero
  - bit1 AN: result bit 15
  - bit2 AV: signed overflow
  - bit3 AC: carry out of bit 15; for subtracts, 1 means no borrow
  - bit4 AS
  - bits 5 and 7: always 0
  
  AZ and AN are taken from the result before saturation.
- R8: The absolute-value op sets AS to X bit 15. No other op changes AS. The absolute value of 0x8000 is 0x8000 with AV set.
- R9: With `sat_en` high, an overflowing result written to `ar` becomes 0x7FFF when the true result is positive and 0x8000 when it is negative. Results written to `af` are never saturated.
- R10: With `av_latch_en` high, an executed op ORs its overflow into AV, so AV stays 1 until an op runs with the latch disabled.
- R11: `astat` bit 6 (MV) takes the value of `mv_in` on every rising edge that is not in reset.
- R12: `exec` is 1 for the cycle after an operation executed, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op | input | 5 | Opcode (R2, R3) |
| x_in | input | 16 | X operand |
| y_in | input | 16 | Y operand |
| kval | input | 16 | Constant operand |
| cin | input | 1 | Carry-in |
| bit_n | input | 4 | Bit index for the bit operations |
| to_fb | input | 1 | 1 selects the feedback register as destination |
| cond | input | 4 | Condition code (R4) |
| sat_en | input | 1 | Saturate the result register on overflow |
| av_latch_en | input | 1 | Make AV sticky |
| mv_in | input | 1 | Multiplier overflow flag to store |
| ar | output | 16 | Result register |
| af | output | 16 | Feedback register |
| astat | output | 8 | Status word |
| exec | output | 1 | Previous operation executed |

## Verification
The hardest situation to reach is each condition code in both its true and its false sense. The flags come only from earlier operations, and AS changes only on absolute value, so a flag state cannot be forced directly.

The bench therefore runs a fixed set of flag-setting operations, each with the always condition. Each one produces a known flag pattern, such as a zero difference, a borrow, a positive overflow, a carry with no overflow, or an absolute value of the minimum. Every setup operation is followed by a predicated add under each of the sixteen codes, while `mv_in` alternates between setups.

A tally of true and false outcomes per code then confirms that both senses occurred. Long randomized runs, biased toward the extreme operand values, cover the saturation and sticky-overflow paths as they interact.

// File: rtl/pred_alu_pkg.sv
`timescale 1ns/1ps
package pred_alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,  OP_ADDC  = 5'd1,  OP_XC    = 5'd2,  OP_XK    = 5'd3,
    OP_SUB   = 5'd4,  OP_SUBB  = 5'd5,  OP_RSUB  = 5'd6,  OP_RSUBB = 5'd7,
    OP_NEGX  = 5'd8,  OP_ANDY  = 5'd9,  OP_ORY   = 5'd10, OP_XORY  = 5'd11,
    OP_ANDK  = 5'd12, OP_ORK   = 5'd13, OP_XORK  = 5'd14, OP_PASSX = 5'd15,
    OP_PASSY = 5'd16, OP_PASSK = 5'd17, OP_NOTX  = 5'd18, OP_ABS   = 5'd19,
    OP_INCY  = 5'd20, OP_DECY  = 5'd21, OP_TSTB  = 5'd22, OP_SETB  = 5'd23,
    OP_CLRB  = 5'd24, OP_TGLB  = 5'd25
  } alu_op_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_GT = 4'd2,  CC_LE = 4'd3,
    CC_LT = 4'd4,  CC_GE = 4'd5,  CC_OV = 4'd6,  CC_NOV = 4'd7,
    CC_CY = 4'd8,  CC_NCY = 4'd9, CC_NEG = 4'd10, CC_POS = 4'd11,
    CC_MV = 4'd12, CC_NMV = 4'd13, CC_NEVER = 4'd14, CC_ALWAYS = 4'd15
  } cond_e;

  typedef struct packed {
    logic mv;
    logic xs;
    logic c;
    logic v;
    logic n;
    logic z;
  } flags_t;

  localparam int STAT_W = 8;
endpackage

// File: rtl/pred_alu_cond.sv
`timescale 1ns/1ps
module pred_alu_cond
  import pred_alu_pkg::*;
(
  input  cond_e  cond,
  input  flags_t fl,
  output logic   take
);
  logic lt;
  logic le;

  assign lt = fl.n ^ fl.v;
  assign le = lt | fl.z;

  always_comb begin
    case (cond)
      CC_EQ:     take = fl.z;
      CC_NE:     take = ~fl.z;
      CC_GT:     take = ~le;
      CC_LE:     take = le;
      CC_LT:     take = lt;
      CC_GE:     take = ~lt;
      CC_OV:     take = fl.v;
      CC_NOV:    take = ~fl.v;
      CC_CY:     take = fl.c;
      CC_NCY:    take = ~fl.c;
      CC_NEG:    take = fl.xs;
      CC_POS:    take = ~fl.xs;
      CC_MV:     take = fl.mv;
      CC_NMV:    take = ~fl.mv;
      CC_NEVER:  take = 1'b0;
      default:   take = 1'b1;
    endcase
  end
endmodule

// File: rtl/pred_alu_core.sv
`timescale 1ns/1ps
module pred_alu_core
  import pred_alu_pkg::*;
#(
  parameter int W  = 16,
  parameter int BW = $clog2(W)
) (
  input  alu_op_e       op,
  input  logic [W-1:0]  x,
  input  logic [W-1:0]  y,
  input  logic [W-1:0]  k,
  input  logic          cin,
  input  logic [BW-1:0] bit_n,
  output logic [W-1:0]  res,
  output logic          ovf,
  output logic          cry,
  output logic          known,
  output logic          abs_op
);
  logic [W-1:0] a, b, lres, mask;
  logic         ci, arith;
  logic [W:0]   sum;

  assign mask = {{(W-1){1'b0}}, 1'b1} << bit_n;

  always_comb begin
    a      = '0;
    b      = '0;
    ci     = 1'b0;
    arith  = 1'b1;
    known  = 1'b1;
    abs_op = 1'b0;
    lres   = '0;
    case (op)
      OP_ADD:   begin a = x; b = y; end
      OP_ADDC:  begin a = x; b = y; ci = cin; end
      OP_XC:    begin a = x; ci = cin; end
      OP_XK:    begin a = x; b = k; end
      OP_SUB:   begin a = x; b = ~y; ci = 1'b1; end
      OP_SUBB:  begin a = x; b = ~y; ci = cin; end
      OP_RSUB:  begin a = y; b = ~x; ci = 1'b1; end
      OP_RSUBB: begin a = y; b = ~x; ci = cin; end
      OP_NEGX:  begin b = ~x; ci = 1'b1; end
      OP_ABS: begin
        abs_op = 1'b1;
        if (x[W-1]) begin b = ~x; ci = 1'b1; end
        else        a = x;
      end
      OP_INCY:  begin a = y; ci = 1'b1; end
      OP_DECY:  begin a = y; b = '1; end
      OP_ANDY:  begin arith = 1'b0; lres = x & y; end
      OP_ORY:   begin arith = 1'b0; lres = x | y; end
      OP_XORY:  begin arith = 1'b0; lres = x ^ y; end
      OP_ANDK:  begin arith = 1'b0; lres = x & k; end
      OP_ORK:   begin arith = 1'b0; lres = x | k; end
      OP_XORK:  begin arith = 1'b0; lres = x ^ k; end
      OP_PASSX: begin arith = 1'b0; lres = x; end
      OP_PASSY: begin arith = 1'b0; lres = y; end
      OP_PASSK: begin arith = 1'b0; lres = k; end
      OP_NOTX:  begin arith = 1'b0; lres = ~x; end
      OP_TSTB:  begin arith = 1'b0; lres = x & mask; end
      OP_SETB:  begin arith = 1'b0; lres = x | mask; end
      OP_CLRB:  begin arith = 1'b0; lres = x & ~mask; end
      OP_TGLB:  begin arith = 1'b0; lres = x ^ mask; end
      default:  begin arith = 1'b0; known = 1'b0; end
    endcase
  end

  assign sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
  assign res = arith ? sum[W-1:0] : lres;
  assign ovf = arith & (a[W-1] == b[W-1]) & (sum[W-1] != a[W-1]);
  assign cry = arith & sum[W];
endmodule

// File: rtl/pred_alu_sat.sv
`timescale 1ns/1ps
module pred_alu_sat #(
  parameter int W = 16
) (
  input  logic [W-1:0] din,
  input  logic         ovf,
  input  logic         en,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  // a wrapped overflow shows the opposite sign of the true result
  assign dout = (en && ovf) ? (din[W-1] ? POS_LIM : NEG_LIM) : din;
endmodule

// File: rtl/pred_alu.sv
`timescale 1ns/1ps
module pred_alu
  import pred_alu_pkg::*;
#(
  parameter int W  = 16,
  parameter int BW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [4:0]    op,
  input  logic [W-1:0]  x_in,
  input  logic [W-1:0]  y_in,
  input  logic [W-1:0]  kval,
  input  logic          cin,
  input  logic [BW-1:0] bit_n,
  input  logic          to_fb,
  input  logic [3:0]    cond,
  input  logic          sat_en,
  input  logic          av_latch_en,
  input  logic          mv_in,
  output logic [W-1:0]  ar,
  output logic [W-1:0]  af,
  output logic [STAT_W-1:0] astat,
  output logic          exec
);
  logic [W-1:0] ar_q, af_q, raw, sat_val;
  flags_t       fl_q;
  logic         exec_q, take, ovf, cry, known, abs_op, fire;

  pred_alu_cond u_cond (
    .cond (cond_e'(cond)),
    .fl   (fl_q),
    .take (take)
  );

  pred_alu_core #(.W(W), .BW(BW)) u_core (
    .op     (alu_op_e'(op)),
    .x      (x_in),
    .y      (y_in),
    .k      (kval),
    .cin    (cin),
    .bit_n  (bit_n),
    .res    (raw),
    .ovf    (ovf),
    .cry    (cry),
    .known  (known),
    .abs_op (abs_op)
  );

  pred_alu_sat #(.W(W)) u_sat (
    .din  (raw),
    .ovf  (ovf),
    .en   (sat_en),
    .dout (sat_val)
  );

  assign fire = op_valid & known & take;

  always_ff @(posedge clk) begin
    if (rst) begin
      ar_q   <= '0;
      af_q   <= '0;
      fl_q   <= '0;
      exec_q <= 1'b0;
    end else begin
      exec_q  <= fire;
      fl_q.mv <= mv_in;
      if (fire) begin
        if (to_fb) af_q <= raw;
        else       ar_q <= sat_val;
        fl_q.z <= (raw == '0);
        fl_q.n <= raw[W-1];
        fl_q.v <= av_latch_en ? (fl_q.v | ovf) : ovf;
        fl_q.c <= cry;
        if (abs_op) fl_q.xs <= x_in[W-1];
      end
    end
  end

  assign ar    = ar_q;
  assign af    = af_q;
  assign exec  = exec_q;
  assign astat = {1'b0, fl_q.mv, 1'b0, fl_q.xs, fl_q.c, fl_q.v, fl_q.n, fl_q.z};
endmodule

// File: rtl/pred_alu_chk.sv
`timescale 1ns/1ps
module pred_alu_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         op_valid,
  input logic         to_fb,
  input logic         av_latch_en,
  input logic         mv_in,
  input logic [W-1:0] ar,
  input logic [W-1:0] af,
  input logic [7:0]   astat,
  input logic         exec
);
  logic armed;
  always_ff @(posedge clk) armed <= ~rst;

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    armed && !exec |-> $stable(ar) && $stable(af) && $stable(astat[4:0])); // R5

  AST_ONE_DEST: assert property (@(posedge clk) disable iff (rst)
    armed |-> !(($past(ar) != ar) && ($past(af) != af))); // R6

  AST_ZN_MATCH: assert property (@(posedge clk) disable iff (rst)
    op_valid && !to_fb && !av_latch_en |=>
      (!(exec && !astat[2]) || ((astat[0] == (ar == '0)) && (astat[1] == ar[W-1])))); // R7

  AST_AV_STICKY: assert property (@(posedge clk) disable iff (rst)
    av_latch_en && astat[2] |=> astat[2]); // R10

  AST_MV_TRACK: assert property (@(posedge clk) disable iff (rst)
    armed |-> astat[6] == $past(mv_in)); // R11

  AST_NO_EXEC_IDLE: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !exec); // R12
endmodule

bind pred_alu pred_alu_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op_valid    (op_valid),
  .to_fb       (to_fb),
  .av_latch_en (av_latch_en),
  .mv_in       (mv_in),
  .ar          (ar),
  .af          (af),
  .astat       (astat),
  .exec        (exec)
);

// File: tb/pred_alu_bench.sv
`timescale 1ns/1ps
module pred_alu_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, op_valid, cin, to_fb, sat_en, av_latch_en, mv_in;
  logic [4:0]  op;
  logic [15:0] x_in, y_in, kval;
  logic [3:0]  bit_n, cond;
  logic [15:0] ar, af;
  logic [7:0]  astat;
  logic        exec;

  pred_alu u_pred_alu (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .x_in(x_in), .y_in(y_in),
    .kval(kval), .cin(cin), .bit_n(bit_n), .to_fb(to_fb), .cond(cond),
    .sat_en(sat_en), .av_latch_en(av_latch_en), .mv_in(mv_in),
    .ar(ar), .af(af), .astat(astat), .exec(exec)
  );

  int n_run = 0, n_fail = 0;
  int m_ar = 0, m_af = 0, m_st = 0, m_ex = 0;
  string tag_ar = "R1", tag_af = "R1", tag_st = "R1";
  int seen_t[16], seen_f[16];

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit cond_ok(input int cc, input int st);
    bit z, n, v, c, s, mv;
    z = st[0]; n = st[1]; v = st[2]; c = st[3]; s = st[4]; mv = st[6];
    case (cc)
      0: return z;               1: return !z;
      2: return !((n ^ v) | z);  3: return (n ^ v) | z;
      4: return n ^ v;           5: return !(n ^ v);
      6: return v;               7: return !v;
      8: return c;               9: return !c;
      10: return s;              11: return !s;
      12: return mv;             13: return !mv;
      14: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic compare();
    chk(tag_ar, int'(ar), m_ar);
    chk(tag_af, int'(af), m_af);
    chk(tag_st, int'(astat), m_st);
    chk("R11 mv", int'(astat[6]), (m_st >> 6) & 1);
    chk("R12 exec", int'(exec), m_ex);
  endtask

  task automatic apply(input int op_i, input int x_i, input int y_i, input int k_i,
                       input int cin_i, input int n_i, input int fb_i, input int cc_i,
                       input int sat_i, input int lat_i, input int mv_i, input int vld_i);
    int sx, sy, sk, ua, ub, ci, sv, r, c, v, t, mask, st;
    bit arith, ok;
    @(negedge clk);
    compare();
    op = op_i[4:0]; x_in = x_i[15:0]; y_in = y_i[15:0]; kval = k_i[15:0];
    cin = cin_i[0]; bit_n = n_i[3:0]; to_fb = fb_i[0]; cond = cc_i[3:0];
    sat_en = sat_i[0]; av_latch_en = lat_i[0]; mv_in = mv_i[0]; op_valid = vld_i[0];
    ok = cond_ok(cc_i, m_st);
    if (vld_i != 0 && cc_i < 14) begin
      if (ok) seen_t[cc_i]++; else seen_f[cc_i]++;
    end
    m_ex = (vld_i != 0 && op_i <= 25 && ok) ? 1 : 0;
    st = m_st;
    if (m_ex == 1) begin
      sx = x_i >= 32768 ? x_i - 65536 : x_i;
      sy = y_i >= 32768 ? y_i - 65536 : y_i;
      sk = k_i >= 32768 ? k_i - 65536 : k_i;
      mask = 1 << (n_i & 15);
      ua = 0; ub = 0; ci = 0; sv = 0; r = 0; arith = 1;
      case (op_i)
        0: begin ua = x_i; ub = y_i; sv = sx + sy; end
        1: begin ua = x_i; ub = y_i; ci = cin_i; sv = sx + sy + cin_i; end
        2: begin ua = x_i; ci = cin_i; sv = sx + cin_i; end
        3: begin ua = x_i; ub = k_i; sv = sx + sk; end
        4: begin ua = x_i; ub = 65535 - y_i; ci = 1; sv = sx - sy; end
        5: begin ua = x_i; ub = 65535 - y_i; ci = cin_i; sv = sx - sy + cin_i - 1; end
        6: begin ua = y_i; ub = 65535 - x_i; ci = 1; sv = sy - sx; end
        7: begin ua = y_i; ub = 65535 - x_i; ci = cin_i; sv = sy - sx + cin_i - 1; end
        8: begin ub = 65535 - x_i; ci = 1; sv = -sx; end
        19: begin
          if (sx < 0) begin ub = 65535 - x_i; ci = 1; sv = -sx; end
          else begin ua = x_i; sv = sx; end
        end
        20: begin ua = y_i; ci = 1; sv = sy + 1; end
        21: begin ua = y_i; ub = 65535; sv = sy - 1; end
        default: arith = 0;
      endcase
      if (!arith) begin
        case (op_i)
          9: r = x_i & y_i;   10: r = x_i | y_i;   11: r = x_i ^ y_i;
          12: r = x_i & k_i;  13: r = x_i | k_i;   14: r = x_i ^ k_i;
          15: r = x_i;        16: r = y_i;         17: r = k_i;
          18: r = (~x_i) & 65535;
          22: r = x_i & mask; 23: r = x_i | mask;
          24: r = x_i & (~mask) & 65535;
          default: r = x_i ^ mask;
        endcase
        c = 0; v = 0;
      end else begin
        t = ua + ub + ci;
        r = t & 65535;
        c = t >> 16;
        v = (sv < -32768 || sv > 32767) ? 1 : 0;
      end
      if (fb_i != 0) m_af = r;
      else if (sat_i != 0 && v == 1) m_ar = (sv > 0) ? 32767 : 32768;
      else m_ar = r;
      if (lat_i != 0) v = v | ((st >> 2) & 1);
      st = (st & 16) | ((r == 0) ? 1 : 0) | (((r >> 15) & 1) << 1) | (v << 2) | (c << 3);
      if (op_i == 19) st = (st & ~16) | (((x_i >> 15) & 1) << 4);
      tag_ar = (sat_i != 0 && v == 1 && fb_i == 0) ? "R9 ar" : (op_i == 19) ? "R8 ar" :
               arith ? "R2 ar" : "R3 ar";
      tag_af = "R6 af";
      tag_st = (lat_i != 0) ? "R10 astat" : (op_i == 19) ? "R8 astat" : "R7 astat";
    end else begin
      tag_ar = "R5 ar"; tag_af = "R5 af"; tag_st = "R5 astat";
    end
    m_st = (st & 8'h1F) | ((mv_i & 1) << 6);
  endtask

  function automatic int pick();
    case ($urandom_range(0, 5))
      0: return 0;
      1: return 1;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'hFFFF;
      default: return int'($urandom_range(0, 65535));
    endcase
  endfunction

  int setup_op[7] = '{4, 4, 0, 0, 19, 19, 0};
  int setup_x[7]  = '{5, 3, 16'h7FFF, 16'hFFFF, 16'h8000, 5, 1};
  int setup_y[7]  = '{5, 5, 1, 1, 0, 0, 1};
  bit done = 0;

  initial begin
    rst = 1; op_valid = 0; op = 0; x_in = 0; y_in = 0; kval = 0; cin = 0;
    bit_n = 0; to_fb = 0; cond = 15; sat_en = 0; av_latch_en = 0; mv_in = 0;
    for (int i = 0; i < 16; i++) begin seen_t[i] = 0; seen_f[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ar", int'(ar), 0);
    chk("R1 af", int'(af), 0);
    chk("R1 astat", int'(astat), 0);
    chk("R1 exec", int'(exec), 0);
    rst = 0;

    // R4: every code after each flag-shaping setup
    for (int s = 0; s < 7; s++) begin
      for (int cc = 0; cc < 16; cc++) begin
        apply(setup_op[s], setup_x[s], setup_y[s], 0, 0, 0, 0, 15, 0, 0, s & 1, 1);
        apply(0, 16'h1234, cc, 0, 0, 0, cc & 1, cc, 0, 0, s & 1, 1);
      end
    end

    // R9: saturation both directions, and none into af
    apply(0, 16'h7FFF, 1, 0, 0, 0, 0, 15, 1, 0, 0, 1);
    apply(4, 16'h8000, 1, 0, 0, 0, 0, 15, 1, 0, 0, 1);
    apply(19, 16'h8000, 0, 0, 0, 0, 0, 15, 1, 0, 0, 1);
    apply(0, 16'h7FFF, 1, 0, 0, 0, 1, 15, 1, 0, 0, 1);

    // R10: sticky overflow, then cleared with latch off
    apply(0, 16'h7FFF, 1, 0, 0, 0, 0, 15, 0, 1, 0, 1);
    apply(0, 1, 1, 0, 0, 0, 0, 15, 0, 1, 0, 1);
    apply(9, 3, 1, 0, 0, 0, 0, 15, 0, 1, 0, 1);
    apply(0, 1, 1, 0, 0, 0, 0, 15, 0, 0, 0, 1);

    // R5: idle, never, undefined opcode
    apply(0, 5, 5, 0, 0, 0, 0, 15, 0, 0, 1, 0);
    apply(0, 5, 5, 0, 0, 0, 0, 14, 0, 0, 1, 1);
    apply(30, 5, 5, 0, 0, 0, 0, 15, 0, 0, 0, 1);

    // R3: bit operations over all positions
    for (int b = 0; b < 16; b++) begin
      apply(22 + (b & 3), 16'hA5C3, 0, 0, 0, b, b & 1, 15, 0, 0, 0, 1);
    end

    // R2 and the rest under random stimulus
    for (int i = 0; i < 4000; i++) begin
      apply($urandom_range(0, 31), pick(), pick(), pick(), $urandom_range(0, 1),
            $urandom_range(0, 15), $urandom_range(0, 1),
            ($urandom_range(0, 3) == 0) ? 15 : $urandom_range(0, 15),
            $urandom_range(0, 1), ($urandom_range(0, 3) == 0) ? 1 : 0,
            $urandom_range(0, 1), ($urandom_range(0, 7) == 0) ? 0 : 1);
    end
    @(negedge clk);
    compare();

    for (int cc = 0; cc < 14; cc++) begin
      chk($sformatf("R4 cover code %0d", cc), int'(seen_t[cc] > 0 && seen_f[cc] > 0), 1);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule